// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an up-counting timer with a parameter-selected width of 8 or 16 bits. A three-bit source field decides what advances the counter: nothing, the system clock on every cycle, one of four divided rates taken from a free-running divider, or the edges of an external pin after synchronization. The counter either runs freely and wraps, or returns to zero after reaching the value held in compare register A.

Two compare channels watch the counter. On a match, each channel applies its own output action (toggle, drive low or drive high) to its waveform pin and raises its match flag. Together with the overflow flag, these flags feed three interrupt requests, and each request is gated by its own enable bit. Software writes every setting through one write port that takes an address and a data word. A force strobe lets software apply a channel's output action without a match.

The current count is brought out so that the host can observe the timer.

Top module: `tmr_core`

## Requirements
- R1: The source field is bits [2:0] of the control word (address 3). The codes are: 0 holds the count unchanged; 1 advances it on every cycle; 2, 3, 4 and 5 advance it once every 8, 64, 256 and 1024 cycles, with the divider running freely.
- R2: Source code 7 advances the count by one for each rising edge of `ext_clk`, and code 6 advances it by one for each falling edge. Each edge counts exactly once and is seen after a two-flop synchronizer.
- R3: When control bit 3 is 0, the count steps up by one on each advance and wraps from all-ones to zero. The advance that leaves all-ones sets flag bit 0 (overflow).
- R4: When control bit 3 is 1, an advance taken while the count equals compare A (address 1) loads zero. The overflow flag is still set only when the count advances out of all-ones.
- R5: The output action of channel A is control bits [5:4], and that of channel B is bits [7:6]. The codes are: 00 drives the pin low (disconnected), 01 toggles on a match, 10 clears on a match, 11 sets on a match.
- R6: An advance taken while the count equals compare A sets flag bit 1. An advance taken while the count equals compare B (address 2) sets flag bit 2.
- R7: Writing address 5 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. If a set and a clear happen in the same cycle, the set wins.
- R8: Interrupt request bit i is high exactly when flag bit i and enable bit i (address 6) are both 1.
- R9: A write to a compare register takes effect on the next cycle, with no wait for a wrap.
- R10: Writing address 4 with data bit 0 (channel A) or data bit 1 (channel B) applies that channel's output action once and does not set its flag.
- R11: Writing address 0 loads the count. The load takes priority over an advance in the same cycle.
- R12: In clear-on-compare mode with toggle output and source code 1, the pin period is 2·(1+compare A) cycles.

Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| ext_clk | input | 1 | External count pin, asynchronous |
| count_o | output | CNT_W | Current counter value |
| pin_a | output | 1 | Channel A waveform |
| pin_b | output | 1 | Channel B waveform |
| flags_o | output | 3 | {match B, match A, overflow} |
| irq_o | output | 3 | Flags gated by enables |

## Verification
The channel assertions assume that the output action code is meant to hold across the cycle in which a match is reported. The stimulus therefore changes the control word only while the source is stopped, or in phases where no match is pending. The counter assertions exclude cycles in which the count is written, and the bench never writes the count in the same cycle as a control change. The external pin is driven with pulses lasting four cycles, which is wider than the synchronizer depth, so no edge is lost.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   typedef enum logic [2:0] {
      SRC_STOP = 3'd0, SRC_DIV1 = 3'd1, SRC_DIV8 = 3'd2, SRC_DIV64 = 3'd3,
      SRC_DIV256 = 3'd4, SRC_DIV1024 = 3'd5, SRC_EXT_FALL = 3'd6, SRC_EXT_RISE = 3'd7
   } src_e;

   typedef enum logic [1:0] {
      ACT_OFF = 2'd0, ACT_TOGGLE = 2'd1, ACT_CLEAR = 2'd2, ACT_SET = 2'd3
   } act_e;

   typedef struct packed {
      act_e mode_b;
      act_e mode_a;
      logic ctc;
      src_e src;
   } ctrl_t;

   localparam logic [2:0] ADR_COUNT = 3'd0;
   localparam logic [2:0] ADR_CMPA  = 3'd1;
   localparam logic [2:0] ADR_CMPB  = 3'd2;
   localparam logic [2:0] ADR_CTRL  = 3'd3;
   localparam logic [2:0] ADR_FORCE = 3'd4;
   localparam logic [2:0] ADR_CLEAR = 3'd5;
   localparam logic [2:0] ADR_ENAB  = 3'd6;

   localparam int NUM_CH   = 2;
   localparam int NUM_FLAG = 3;
endpackage

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
module tmr_edge #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int CHAIN = SYNC_N + 1;

   if (SYNC_N < 2) begin : g_bad_sync
      $error("tmr_edge: SYNC_N must be at least 2");
   end

   logic [CHAIN-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], pin_i};
   end

   assign rise_o =  chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
   assign fall_o = ~chain_q[CHAIN-2] &  chain_q[CHAIN-1];
endmodule

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int PRE_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  src_e src_i,
   input  logic ext_rise_i,
   input  logic ext_fall_i,
   output logic tick_o
);
   localparam int B8    = 3;
   localparam int B64   = 6;
   localparam int B256  = 8;
   localparam int B1024 = 10;

   if (PRE_W < B1024) begin : g_bad_pre
      $error("tmr_prescale: PRE_W must cover a divide by 1024");
   end

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      case (src_i)
         SRC_STOP:     tick_o = 1'b0;
         SRC_DIV1:     tick_o = 1'b1;
         SRC_DIV8:     tick_o = &pre_q[B8-1:0];
         SRC_DIV64:    tick_o = &pre_q[B64-1:0];
         SRC_DIV256:   tick_o = &pre_q[B256-1:0];
         SRC_DIV1024:  tick_o = &pre_q[B1024-1:0];
         SRC_EXT_FALL: tick_o = ext_fall_i;
         SRC_EXT_RISE: tick_o = ext_rise_i;
         default:      tick_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             tick_i,
   input  act_e             mode_i,
   input  logic             force_i,
   output logic             hit_o,
   output logic             pin_o
);
   logic state_q;
   logic fire;

   assign hit_o = tick_i && (count_i == cmp_i);
   assign fire  = hit_o || force_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= 1'b0;
      else if (fire) begin
         case (mode_i)
            ACT_TOGGLE: state_q <= ~state_q;
            ACT_CLEAR:  state_q <= 1'b0;
            ACT_SET:    state_q <= 1'b1;
            default:    state_q <= state_q;
         endcase
      end
   end

   assign pin_o = (mode_i == ACT_OFF) ? 1'b0 : state_q;

   AST_SET_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode_i == ACT_SET) |=> state_q) else $error("set action"); // R5
   AST_CLEAR_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode_i == ACT_CLEAR) |=> !state_q) else $error("clear action"); // R5
   AST_TOGGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode_i == ACT_TOGGLE) |=> (state_q != $past(state_q))) else $error("toggle"); // R5
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int PRE_W  = 10,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ext_clk,
   output logic [CNT_W-1:0] count_o,
   output logic             pin_a,
   output logic             pin_b,
   output logic [2:0]       flags_o,
   output logic [2:0]       irq_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam int CTRL_W = $bits(ctrl_t);

   if (!(CNT_W == 8 || CNT_W == 16)) begin : g_bad_width
      $error("tmr_core: CNT_W must be 8 or 16");
   end

   ctrl_t                   ctrl_q;
   logic [CNT_W-1:0]        count_q;
   logic [CNT_W-1:0]        cmp_q [NUM_CH];
   logic [NUM_FLAG-1:0]     flag_q;
   logic [NUM_FLAG-1:0]     enab_q;
   logic [NUM_CH-1:0]       hit;
   logic [NUM_CH-1:0]       pin;
   logic [NUM_CH-1:0]       force_pulse;
   logic [NUM_FLAG-1:0]     flag_set;
   logic [NUM_FLAG-1:0]     flag_clr;
   logic                    tick;
   logic                    ext_rise;
   logic                    ext_fall;
   logic                    cnt_wr;
   act_e                    ch_mode [NUM_CH];

   assign cnt_wr = wr_en && (wr_addr == ADR_COUNT);

   tmr_edge #(.SYNC_N(SYNC_N)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_clk),
      .rise_o(ext_rise), .fall_o(ext_fall)
   );

   tmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .src_i(ctrl_q.src),
      .ext_rise_i(ext_rise), .ext_fall_i(ext_fall), .tick_o(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         enab_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_addr == ADR_ENAB) enab_q <= wr_data[NUM_FLAG-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_q <= '0;
      else if (cnt_wr) count_q <= wr_data;
      else if (tick) begin
         if (ctrl_q.ctc && (count_q == cmp_q[0])) count_q <= '0;
         else                                      count_q <= count_q + 1'b1;
      end
   end

   assign ch_mode[0] = ctrl_q.mode_a;
   assign ch_mode[1] = ctrl_q.mode_b;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cmp_q[c] <= '0;
         else if (wr_en && (wr_addr == ADR_CMPA + 3'(c))) cmp_q[c] <= wr_data;
      end

      assign force_pulse[c] = wr_en && (wr_addr == ADR_FORCE) && wr_data[c];

      tmr_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .count_i(count_q), .cmp_i(cmp_q[c]),
         .tick_i(tick && !cnt_wr), .mode_i(ch_mode[c]), .force_i(force_pulse[c]),
         .hit_o(hit[c]), .pin_o(pin[c])
      );
   end

   assign flag_set = {hit, tick && !cnt_wr && (count_q == CNT_MAX)};
   assign flag_clr = (wr_en && (wr_addr == ADR_CLEAR)) ? wr_data[NUM_FLAG-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~flag_clr) | flag_set;
   end

   assign count_o = count_q;
   assign pin_a   = pin[0];
   assign pin_b   = pin[1];
   assign flags_o = flag_q;
   assign irq_o   = flag_q & enab_q;

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.src == SRC_STOP && !cnt_wr) |=> (count_q == $past(count_q))) else $error("stop"); // R1
   AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.ctc && tick && !cnt_wr) |=> (count_q == CNT_W'($past(count_q) + 1'b1))) else $error("step"); // R3
   AST_CTC_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.ctc && tick && !cnt_wr && count_q == cmp_q[0]) |=> (count_q == '0)) else $error("ctc"); // R4
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && count_q == CNT_MAX) |=> flag_q[0]) else $error("ovf"); // R3
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count_q == $past(wr_data))) else $error("load"); // R11
endmodule

// File: tb/sim_tmr_core.sv
`timescale 1ns/1ps
module sim_tmr_core;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         ext_clk = 1'b0;
   logic [W-1:0] count_o;
   logic         pin_a, pin_b;
   logic [2:0]   flags_o, irq_o;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   tmr_core #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ext_clk(ext_clk), .count_o(count_o), .pin_a(pin_a), .pin_b(pin_b),
      .flags_o(flags_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] ctl(input int src, input int ctc, input int ma, input int mb);
      return {2'(mb), 2'(ma), 1'(ctc), 3'(src)};
   endfunction

   task automatic stop_clean();
      wr(3, 8'h00); wr(0, 8'h00); wr(5, 8'h07); wr(6, 8'h00);
   endtask

   task automatic t_reset();
      chk("R11 reset count", count_o, 0);
      chk("R6 reset flags", flags_o, 0);
      chk("R8 reset irq", irq_o, 0);
      chk("R5 reset pins", {pin_b, pin_a}, 0);
   endtask

   task automatic t_sources();
      int c0;
      stop_clean();
      wr(0, 8'd5); cyc(20);
      chk("R1 stopped holds", count_o, 5);
      wr(0, 8'd0);
      wr(3, ctl(1, 0, 0, 0)); c0 = count_o; cyc(10);
      chk("R1 undivided", count_o, c0 + 10);
      wr(3, 8'h00); wr(0, 8'd0);
      wr(3, ctl(2, 0, 0, 0)); c0 = count_o; cyc(80);
      chk("R1 divide 8", count_o, c0 + 10);
      wr(3, 8'h00); c0 = count_o; cyc(50);
      chk("R1 freeze after stop", count_o, c0);
      wr(0, 8'd0);
      wr(3, ctl(3, 0, 0, 0)); c0 = count_o; cyc(640);
      chk("R1 divide 64", count_o, c0 + 10);
      wr(3, 8'h00); wr(0, 8'd0);
      wr(3, ctl(4, 0, 0, 0)); c0 = count_o; cyc(768);
      chk("R1 divide 256", count_o, c0 + 3);
      wr(3, 8'h00); wr(0, 8'd0);
      wr(3, ctl(5, 0, 0, 0)); c0 = count_o; cyc(2048);
      chk("R1 divide 1024", count_o, c0 + 2);
   endtask

   task automatic t_ext();
      stop_clean();
      ext_clk = 1'b0;
      wr(3, ctl(7, 0, 0, 0));
      for (int i = 0; i < 5; i++) begin
         cyc(4); ext_clk = 1'b1; cyc(4); ext_clk = 1'b0;
      end
      cyc(6);
      chk("R2 rising edges", count_o, 5);
      wr(3, ctl(6, 0, 0, 0));
      for (int i = 0; i < 3; i++) begin
         cyc(4); ext_clk = 1'b1; cyc(4); ext_clk = 1'b0;
      end
      cyc(6);
      chk("R2 falling edges", count_o, 8);
   endtask

   task automatic t_wrap();
      stop_clean();
      wr(0, 8'd250);
      wr(3, ctl(1, 0, 0, 0));
      cyc(5);
      chk("R3 at all-ones", count_o, 255);
      chk("R3 no overflow yet", flags_o[0], 0);
      cyc(1);
      chk("R3 wrapped", count_o, 0);
      chk("R3 overflow flag", flags_o[0], 1);
   endtask

   task automatic t_ctc();
      int prev, changes;
      stop_clean();
      wr(1, 8'd4); wr(2, 8'd2);
      wr(3, ctl(1, 1, 1, 3));
      cyc(2);
      chk("R5 set pin before match", pin_b, 0);
      cyc(1);
      chk("R5 set pin on match", pin_b, 1);
      chk("R6 flag B", flags_o[2], 1);
      cyc(1);
      chk("R4 reaches compare", count_o, 4);
      chk("R5 toggle pin before match", pin_a, 0);
      cyc(1);
      chk("R4 returns to zero", count_o, 0);
      chk("R5 toggle pin on match", pin_a, 1);
      chk("R6 flag A", flags_o[1], 1);
      prev = pin_a; changes = 0;
      for (int i = 0; i < 40; i++) begin
         cyc(1);
         if (pin_a != prev) changes++;
         prev = pin_a;
      end
      chk("R12 toggles in 40 cycles", changes, 8);
      chk("R4 no overflow below all-ones", flags_o[0], 0);
   endtask

   task automatic t_flags_irq();
      wr(3, 8'h00);
      chk("R7 flags before clear", flags_o, 6);
      wr(5, 8'h00);
      chk("R7 zero write no effect", flags_o, 6);
      wr(5, 8'h02);
      chk("R7 clear A only", flags_o, 4);
      wr(6, 8'h00);
      chk("R8 disabled", irq_o, 0);
      wr(6, 8'h07);
      chk("R8 enabled B only", irq_o, 4);
      wr(5, 8'h04);
      chk("R8 irq drops with flag", irq_o, 0);
   endtask

   task automatic t_force();
      logic pb;
      wr(5, 8'h07);
      wr(3, ctl(0, 0, 3, 2));
      wr(4, 8'h01);
      chk("R10 force set A", pin_a, 1);
      wr(4, 8'h02);
      chk("R10 force clear B", pin_b, 0);
      wr(3, ctl(0, 0, 3, 1));
      pb = pin_b;
      wr(4, 8'h02);
      chk("R10 force toggle B", pin_b, int'(!pb));
      chk("R10 no flag from force", flags_o, 0);
      wr(3, ctl(0, 0, 0, 1));
      chk("R5 disconnected drives low", pin_a, 0);
   endtask

   task automatic t_immediate();
      int c;
      stop_clean();
      wr(2, 8'd200);
      wr(3, ctl(1, 0, 0, 0));
      cyc(3);
      c = count_o;
      wr(2, 8'(c + 4));
      cyc(5);
      chk("R9 new compare hits at once", flags_o[2], 1);
      wr(0, 8'd77);
      chk("R11 load wins over advance", count_o, 77);
      cyc(3);
      chk("R11 counts on from load", count_o, 80);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_sources();
      t_ext();
      t_wrap();
      t_ctc();
      t_flags_irq();
      t_force();
      t_immediate();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule